// File: doc/BRIEF.md
# Indirect-Window Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt controller and is reached over a simple 32-bit register port with only two legal offsets. The first offset is a select register that holds an 8-bit internal index. The second offset is a data window. A read or write at the window reaches whichever internal register the current select value names.

Behind the window are three registers and a table:
- a controller identity register;
- a read-only version register that reports the table size;
- an arbitration identity register;
- a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves through consecutive indices.

The whole table is exported as a flat vector for the routing logic next to the block. Every access completes in one cycle. The port has no back-pressure: an access is taken on every clock edge where `bus_valid` is high. Read data comes back with `bus_rvalid` exactly one cycle later, and the two strobes `bus_err` and `idx_warn` appear in that same cycle.

Top module: `irq_redir_regs`

## Requirements
- R1: Only word accesses exist. Offset 0 is the select register: a write stores `bus_wdata[7:0]`, and a read returns it zero-extended. Offset 16 is the data window. Every read returns `bus_rvalid` and `bus_rdata` one cycle after the access, and a legal access never raises `bus_err`.
- R2: An access at any other offset raises `bus_err` for one cycle, one cycle after the access. Such a read returns zero. Such a write changes no state.
- R3: Index 0x00 is the controller identity. A write stores `wdata[31:24]`. A read returns the identity in bits 31:24 and zero in all other bits.
- R4: Index 0x01 is the version register. Bits 23:16 read as `N_ENTRIES-1` and bits 7:0 read as `VERSION`; all other bits read as zero. Writes to it are ignored.
- R5: Index 0x02 is the arbitration identity and behaves exactly like R3 in bits 31:24.
- R6: Indices 0x10 up to 0x10+2·N_ENTRIES−1 reach the table. The entry number is (index−0x10)/2. An even index reaches the low half and an odd index reaches the high half. Entry i appears on `redir_entries[64i+63:64i]`, with the high half on top. The table changes only when the window is written.
- R7: Each write to a half stores only its defined fields and clears its reserved bits.
  - In the low half, the defined fields are: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, polarity in bit 13, trigger in bit 15, and mask in bit 16.
  - In the high half, the only defined field is the destination in bits 31:24.
  - All other bits of both halves are reserved and read as zero.
- R8: After reset:
  - every entry is zero except its mask bit (the low half reads 0x0001_0000);
  - the select register is 0;
  - both the controller identity and the arbitration identity equal `INIT_ID`.
- R9: `INIT_ID` must be below 0xFF, because 0xFF is reserved for broadcast. A larger value stops elaboration.
- R10: A window access to any undefined index raises `idx_warn` for one cycle, one cycle after the access. A read of an undefined index returns zero. A write to an undefined index has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, taken every cycle it is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Illegal-offset strobe |
| idx_warn | output | 1 | Undefined-index strobe |
| redir_entries | output | 64·N_ENTRIES | All table entries, entry i at bits 64i+63:64i |

## Verification
The hardest case to reach is a write that has no effect: an undefined index, the version register, or an illegal offset. From the outside such a write looks identical to a dropped access. To expose it, the bench first loads every table half and both identity registers with distinct patterns. It then sweeps all-ones writes across every undefined index and every illegal offset. After the sweep it compares the full exported table, a readback of the select register, and readbacks of both identity registers against the model.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int unsigned DW = 32;

  // Bus offsets
  localparam int unsigned OFF_SELECT = 0;
  localparam int unsigned OFF_WINDOW = 16;

  // Internal indices
  localparam logic [7:0] IDX_IDENT   = 8'h00;
  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_ARBID   = 8'h02;
  localparam logic [7:0] IDX_TBL_LO  = 8'h10;

  // Defined-field masks of each entry half
  localparam logic [DW-1:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [DW-1:0] HI_KEEP = 32'hFF00_0000;

  // Reset value of each low half (mask bit 16 set)
  localparam logic [DW-1:0] LO_RESET = 32'h0001_0000;

  typedef enum logic [2:0] {
    K_IDENT,
    K_VERSION,
    K_ARBID,
    K_TABLE,
    K_UNDEF
  } idx_kind_e;

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned EW       = $clog2(N_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sel,
  output logic              hit_select,
  output logic              hit_window,
  output idx_kind_e         kind,
  output logic [EW-1:0]     entry,
  output logic              upper
);

  localparam logic [8:0] TBL_SPAN = 9'(2 * N_ENTRIES);

  logic [7:0] rel;
  logic       in_tbl;

  assign hit_select = (addr == ADDR_W'(OFF_SELECT));
  assign hit_window = (addr == ADDR_W'(OFF_WINDOW));

  assign rel    = sel - IDX_TBL_LO;
  assign in_tbl = (sel >= IDX_TBL_LO) && ({1'b0, rel} < TBL_SPAN);
  assign entry  = rel[EW:1];
  assign upper  = rel[0];

  always_comb begin
    if (sel == IDX_IDENT)        kind = K_IDENT;
    else if (sel == IDX_VERSION) kind = K_VERSION;
    else if (sel == IDX_ARBID)   kind = K_ARBID;
    else if (in_tbl)             kind = K_TABLE;
    else                         kind = K_UNDEF;
  end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  localparam int unsigned EW       = $clog2(N_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [EW-1:0]            wr_entry,
  input  logic                     wr_upper,
  input  logic [DW-1:0]            wr_data,
  input  logic [EW-1:0]            rd_entry,
  input  logic                     rd_upper,
  output logic [DW-1:0]            rd_data,
  output logic [N_ENTRIES*64-1:0]  entries_flat
);

  logic [DW-1:0] lo_q [N_ENTRIES];
  logic [DW-1:0] hi_q [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_entry == EW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= LO_RESET;
        hi_q[g] <= '0;
      end else if (hit) begin
        if (wr_upper) hi_q[g] <= wr_data & HI_KEEP;
        else          lo_q[g] <= wr_data & LO_KEEP;
      end
    end

    assign entries_flat[g*64 +: 64] = {hi_q[g], lo_q[g]};
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_entry) < N_ENTRIES)
      rd_data = rd_upper ? hi_q[rd_entry] : lo_q[rd_entry];
  end

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  VERSION   = 8'h11,
  parameter logic [7:0]  INIT_ID   = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic                    bus_rvalid,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  output logic                    idx_warn,
  output logic [N_ENTRIES*64-1:0] redir_entries
);

  localparam int unsigned EW = $clog2(N_ENTRIES);
  localparam logic [DW-1:0] VER_WORD = {8'h00, 8'(N_ENTRIES - 1), 8'h00, VERSION};

  if (INIT_ID == 8'hFF) begin : g_bad_id
    $error("INIT_ID 0xFF is reserved for broadcast"); // R9
  end

  logic [7:0]    sel_q, id_q, arb_q;
  logic          hit_select, hit_window;
  idx_kind_e     kind;
  logic [EW-1:0] entry;
  logic          upper;
  logic [DW-1:0] tbl_rd;
  logic          wr_sel, wr_win, rd_acc, illegal, undef_acc;
  logic [DW-1:0] rd_next;

  irq_redir_decode #(
    .N_ENTRIES(N_ENTRIES),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr      (bus_addr),
    .sel       (sel_q),
    .hit_select(hit_select),
    .hit_window(hit_window),
    .kind      (kind),
    .entry     (entry),
    .upper     (upper)
  );

  assign wr_sel    = bus_valid && bus_write && hit_select;
  assign wr_win    = bus_valid && bus_write && hit_window;
  assign rd_acc    = bus_valid && !bus_write;
  assign illegal   = bus_valid && !hit_select && !hit_window;
  assign undef_acc = bus_valid && hit_window && (kind == K_UNDEF);

  irq_redir_table #(
    .N_ENTRIES(N_ENTRIES)
  ) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_win && (kind == K_TABLE)),
    .wr_entry    (entry),
    .wr_upper    (upper),
    .wr_data     (bus_wdata),
    .rd_entry    (entry),
    .rd_upper    (upper),
    .rd_data     (tbl_rd),
    .entries_flat(redir_entries)
  );

  always_comb begin
    rd_next = '0;
    if (hit_select) begin
      rd_next = {24'h0, sel_q};
    end else if (hit_window) begin
      unique case (kind)
        K_IDENT:   rd_next = {id_q, 24'h0};
        K_VERSION: rd_next = VER_WORD;
        K_ARBID:   rd_next = {arb_q, 24'h0};
        K_TABLE:   rd_next = tbl_rd;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= INIT_ID;
      arb_q <= INIT_ID;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && kind == K_IDENT) id_q  <= bus_wdata[31:24];
      if (wr_win && kind == K_ARBID) arb_q <= bus_wdata[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
      idx_warn   <= 1'b0;
    end else begin
      bus_rvalid <= rd_acc;
      bus_rdata  <= rd_acc ? rd_next : '0;
      bus_err    <= illegal;
      idx_warn   <= undef_acc;
    end
  end

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_rvalid,
  input logic [31:0]             bus_rdata,
  input logic                    bus_err,
  input logic                    idx_warn,
  input logic [N_ENTRIES*64-1:0] redir_entries
);

  localparam logic [N_ENTRIES*64-1:0] RSVD = {N_ENTRIES{~HI_KEEP, ~LO_KEEP}};

  logic legal;
  assign legal = (bus_addr == ADDR_W'(OFF_SELECT)) || (bus_addr == ADDR_W'(OFF_WINDOW));

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |=> bus_rvalid); // R1
  AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && legal |=> !bus_err); // R1
  AST_BAD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !legal |=> bus_err); // R2
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !legal |=> bus_rdata == 32'h0); // R2
  AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && bus_write) |-> $stable(redir_entries)); // R6
  AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_entries & RSVD) == '0); // R7
  AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_warn |-> $past(bus_valid) && !bus_err); // R10

endmodule

bind irq_redir_regs irq_redir_chk #(
  .N_ENTRIES(N_ENTRIES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_rvalid   (bus_rvalid),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .idx_warn     (idx_warn),
  .redir_entries(redir_entries)
);

// File: tb/sim_irq_redir_regs.sv
module sim_irq_redir_regs;

  localparam int unsigned N  = 8;
  localparam int unsigned AW = 8;
  localparam logic [7:0]  VER = 8'h11;
  localparam logic [7:0]  IID = 8'h05;
  localparam logic [31:0] LO_K = 32'h0001_AFFF;
  localparam logic [31:0] HI_K = 32'hFF00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid, bus_err, idx_warn;
  logic [31:0] bus_rdata;
  logic [N*64-1:0] redir_entries;

  always #5 clk = ~clk;

  irq_redir_regs #(
    .N_ENTRIES(N), .ADDR_W(AW), .VERSION(VER), .INIT_ID(IID)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .idx_warn(idx_warn),
    .redir_entries(redir_entries)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_sel, m_id, m_arb;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  logic [31:0] r_data;
  logic r_valid, r_err, r_warn;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    r_data = bus_rdata; r_valid = bus_rvalid; r_err = bus_err; r_warn = idx_warn;
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] idx);
    int e;
    if (idx == 8'h00) return {m_id, 24'h0};
    if (idx == 8'h01) return {8'h00, 8'(N - 1), 8'h00, VER};
    if (idx == 8'h02) return {m_arb, 24'h0};
    if (idx >= 8'h10 && int'(idx) < 16 + 2 * N) begin
      e = (int'(idx) - 16) / 2;
      return idx[0] ? m_hi[e] : m_lo[e];
    end
    return 32'h0;
  endfunction

  function automatic bit is_undef(input logic [7:0] idx);
    return !(idx <= 8'h02 || (idx >= 8'h10 && int'(idx) < 16 + 2 * N));
  endfunction

  task automatic check_table(input string req);
    for (int i = 0; i < N; i++)
      check(redir_entries[i*64 +: 64] == {m_hi[i], m_lo[i]}, req,
            redir_entries[i*64 +: 64], {m_hi[i], m_lo[i]});
  endtask

  task automatic win_rd_check(input logic [7:0] idx, input string req);
    acc(1'b1, 8'd0, {24'h0, idx});
    m_sel = idx;
    acc(1'b0, 8'd16, 32'h0);
    check(r_valid && !r_err, "R1", {r_valid, r_err}, 2'b10);
    check(r_data == model_rd(idx), req, r_data, model_rd(idx));
    check(r_warn == is_undef(idx), "R10", r_warn, is_undef(idx));
  endtask

  initial begin
    m_sel = 8'h00; m_id = IID; m_arb = IID;
    for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(!bus_rvalid && !bus_err && !idx_warn, "R8", {bus_rvalid, bus_err, idx_warn}, 0);
    check_table("R8");
    acc(1'b0, 8'd0, 32'h0);
    check(r_data == 32'h0, "R8", r_data, 0);
    acc(1'b0, 8'd16, 32'h0);
    check(r_data == {IID, 24'h0} && IID != 8'hFF, "R9", r_data, {IID, 24'h0});

    // Read sweep over every index (R3 R4 R5 R6 R10)
    for (int k = 0; k < 256; k++) begin
      acc(1'b1, 8'd0, 32'hFFFF_FF00 | 32'(k));
      acc(1'b0, 8'd0, 32'h0);
      check(r_data == 32'(k), "R1", r_data, 32'(k));
      win_rd_check(8'(k), "R6");
    end

    // Fill table with patterns (R6 R7)
    for (int i = 0; i < N; i++) begin
      logic [31:0] p;
      p = 32'hA5C3_96F0 ^ (32'(i) * 32'h0101_0101);
      acc(1'b1, 8'd0, 32'(16 + 2 * i));
      acc(1'b1, 8'd16, p);
      m_lo[i] = p & LO_K;
      acc(1'b1, 8'd0, 32'(17 + 2 * i));
      acc(1'b1, 8'd16, ~p);
      m_hi[i] = ~p & HI_K;
    end
    check_table("R7");
    for (int i = 0; i < 2 * N; i++) win_rd_check(8'(16 + i), "R6");

    // Identity, arbitration and version writes (R3 R4 R5)
    acc(1'b1, 8'd0, 32'h0); acc(1'b1, 8'd16, 32'hC3FF_FFFF); m_id = 8'hC3;
    win_rd_check(8'h00, "R3");
    win_rd_check(8'h02, "R5");
    acc(1'b1, 8'd0, 32'h2); acc(1'b1, 8'd16, 32'h5A12_3456); m_arb = 8'h5A;
    win_rd_check(8'h02, "R5");
    win_rd_check(8'h00, "R3");
    acc(1'b1, 8'd0, 32'h1); acc(1'b1, 8'd16, 32'hFFFF_FFFF);
    check(!r_warn && !r_err, "R4", {r_warn, r_err}, 0);
    win_rd_check(8'h01, "R4");

    // Undefined-index writes have no effect (R10)
    for (int k = 3; k < 256; k++) begin
      if (is_undef(8'(k))) begin
        acc(1'b1, 8'd0, 32'(k));
        acc(1'b1, 8'd16, 32'hFFFF_FFFF);
        check(r_warn && !r_err, "R10", {r_warn, r_err}, 2'b10);
      end
    end
    check_table("R10");
    win_rd_check(8'h00, "R10");
    win_rd_check(8'h02, "R10");

    // Illegal offsets (R2)
    acc(1'b1, 8'd0, 32'h13); m_sel = 8'h13;
    for (int a = 1; a < 256; a++) begin
      if (a != 16) begin
        acc(1'b1, 8'(a), 32'hFFFF_FFFF);
        check(r_err && !r_warn, "R2", {r_err, r_warn}, 2'b10);
        acc(1'b0, 8'(a), 32'h0);
        check(r_err && r_valid && r_data == 32'h0, "R2", {r_err, r_valid, r_data}, {2'b11, 32'h0});
      end
    end
    acc(1'b0, 8'd0, 32'h0);
    check(r_data == 32'h13, "R2", r_data, 32'h13);
    check_table("R2");
    acc(1'b0, 8'd16, 32'h0);
    check(r_data == model_rd(8'h13), "R2", r_data, model_rd(8'h13));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule